// File: doc/BRIEF.md
# Coprocessor Shared-Memory Host Access Port

This block sits between a host bus and a small coprocessor. It holds the coprocessor's shared byte-wide memory and gives the host four byte-wide registers. Two of them load a 16-bit pointer one byte at a time. A third is a data window onto the memory at that pointer. The fourth is a control and status word. When pointer stepping is on, every access to the data window moves the pointer on by one. Loading code into the memory, reading it back or comparing it with a copy therefore needs only one pointer load.

The control word starts and stops the coprocessor and lets the host ring a doorbell that reaches the coprocessor as a one-cycle pulse. It also shows two event flags that the coprocessor can raise: one means outbound work has completed, the other means an inbound message is waiting. Either flag drives the single host interrupt line. The host reads the control word to tell the two flags apart. It clears a flag by writing a 1 to that flag's bit.

The coprocessor core is not part of this block. Its side is a set of plain ports: a run output, a doorbell output, two flag-set inputs and a memory write port. Through that write port the coprocessor can, for example, store 0xFF into an agreed liveness byte. The host then reads that byte and writes 0 back to it.

Top module: `cop_ram_port`

## Requirements
- R1: After reset the coprocessor is held stopped (copRun low), hostIrq is low, the pointer is 0x0000, and the control word reads 0x00.
- R2: Register select 0 loads bits 7:0 of the pointer and select 1 loads bits 15:8, without disturbing the other byte. Reads of select 0 and 1 return the current pointer bytes.
- R3: Select 2 is the data window. A read returns the memory byte at the pointer in the same cycle. A write stores hostWdata there at the clock edge. With pointer stepping off, the pointer does not change.
- R4: With pointer stepping on (control bit 1), each read or write on select 2 advances the pointer by exactly one after the access.
- R5: A stepping access at pointer 0xFFFF leaves the pointer at 0x0000.
- R6: A write to the control word (select 3) sets run from bit 0, which drives copRun, and sets pointer stepping from bit 1. Both bits read back in the same positions.
- R7: Writing the control word with bit 2 set makes copDoorbell high for exactly the one cycle after the write. Bit 2 always reads back as 0.
- R8: A high pulse on copEvt0Set sets event flag 0 (control bit 3), and a high pulse on copEvt1Set sets event flag 1 (control bit 4). A set flag stays set. hostIrq is high whenever either flag is set.
- R9: A control write with bit 3 or bit 4 set clears that flag, and a 0 in that bit leaves the flag unchanged. If the coprocessor sets a flag in the same cycle as the host clears it, the flag ends up set.
- R10: The memory index is the low RAM_AW bits of the pointer, so pointers that differ only above those bits reach the same byte.
- R11: A coprocessor write (copWrEn) stores copWrData at copWrAddr. When a host data write hits the same byte in the same cycle, the host's value is kept. This allows the liveness handshake: the coprocessor writes 0xFF, the host reads 0xFF, writes 0 and then reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 2 | Register select: 0 pointer low, 1 pointer high, 2 data, 3 control |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe (steps the pointer on data reads) |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data for the selected register |
| hostIrq | output | 1 | Host interrupt, OR of the two event flags |
| copRun | output | 1 | Coprocessor run enable |
| copDoorbell | output | 1 | One-cycle doorbell pulse to the coprocessor |
| copEvt0Set | input | 1 | Coprocessor sets event flag 0 (completion) |
| copEvt1Set | input | 1 | Coprocessor sets event flag 1 (new message) |
| copWrEn | input | 1 | Coprocessor memory write enable |
| copWrAddr | input | RAM_AW | Coprocessor memory write address |
| copWrData | input | 8 | Coprocessor memory write data |

## Verification
The properties assume that the host never asserts read and write in the same cycle. They also assume that the doorbell is never rung in two back-to-back cycles, so that each pulse can be traced to a single control write. The bench drives one host access at a time and changes inputs only on falling edges, which keeps inside both assumptions. The flag properties let a coprocessor set and a host clear arrive together. The bench does this on purpose once, to confirm that the set wins.

// File: rtl/cop_port_pkg.sv
package cop_port_pkg;
  typedef enum logic [1:0] {
    SEL_PTR_LO = 2'd0,
    SEL_PTR_HI = 2'd1,
    SEL_DATA   = 2'd2,
    SEL_CTRL   = 2'd3
  } regSel_t;

  localparam int BIT_RUN  = 0;
  localparam int BIT_STEP = 1;
  localparam int BIT_BELL = 2;
  localparam int BIT_EVT0 = 3;
  localparam int NUM_EVT  = 2;

  typedef struct packed {
    logic ldLo;
    logic ldHi;
    logic dataWr;
    logic dataAcc;
  } dpStrobe_t;
endpackage

// File: rtl/cop_port_ctrl.sv
module cop_port_ctrl
  import cop_port_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          hostSel,
  input  logic                hostWrEn,
  input  logic                hostRdEn,
  input  logic [7:0]          hostWdata,
  input  logic [NUM_EVT-1:0]  evtSet,
  input  logic [15:0]         curAddr,
  input  logic [7:0]          ramData,
  output dpStrobe_t           strobe,
  output logic [7:0]          hostRdata,
  output logic                runQ,
  output logic                autoIncQ,
  output logic                bellQ,
  output logic [NUM_EVT-1:0]  evtFlags
);
  logic ctrlWr;
  logic [7:0] statusWord;

  assign ctrlWr = hostWrEn && (hostSel == SEL_CTRL);

  always_comb begin
    strobe.ldLo    = hostWrEn && (hostSel == SEL_PTR_LO);
    strobe.ldHi    = hostWrEn && (hostSel == SEL_PTR_HI);
    strobe.dataWr  = hostWrEn && (hostSel == SEL_DATA);
    strobe.dataAcc = (hostWrEn || hostRdEn) && (hostSel == SEL_DATA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      autoIncQ <= 1'b0;
      bellQ    <= 1'b0;
    end else begin
      bellQ <= ctrlWr && hostWdata[BIT_BELL];
      if (ctrlWr) begin
        runQ     <= hostWdata[BIT_RUN];
        autoIncQ <= hostWdata[BIT_STEP];
      end
    end
  end

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    always_ff @(posedge clk) begin
      if (!rstN)
        evtFlags[e] <= 1'b0;
      else if (evtSet[e])
        evtFlags[e] <= 1'b1;
      else if (ctrlWr && hostWdata[BIT_EVT0 + e])
        evtFlags[e] <= 1'b0;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[BIT_RUN]  = runQ;
    statusWord[BIT_STEP] = autoIncQ;
    statusWord[BIT_EVT0 +: NUM_EVT] = evtFlags;
  end

  always_comb begin
    unique case (hostSel)
      SEL_PTR_LO: hostRdata = curAddr[7:0];
      SEL_PTR_HI: hostRdata = curAddr[15:8];
      SEL_DATA:   hostRdata = ramData;
      default:    hostRdata = statusWord;
    endcase
  end
endmodule

// File: rtl/cop_port_dp.sv
module cop_port_dp
  import cop_port_pkg::*;
#(
  parameter int RAM_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              autoInc,
  input  logic [7:0]        hostWdata,
  input  logic              copWrEn,
  input  logic [RAM_AW-1:0] copWrAddr,
  input  logic [7:0]        copWrData,
  output logic [15:0]       curAddr,
  output logic [7:0]        ramData
);
  localparam int RAM_DEPTH = 1 << RAM_AW;

  logic [7:0] mem [RAM_DEPTH];
  logic [RAM_AW-1:0] idx;

  assign idx     = curAddr[RAM_AW-1:0];
  assign ramData = mem[idx];

  always_ff @(posedge clk) begin
    if (!rstN)
      curAddr <= '0;
    else if (strobe.ldLo)
      curAddr[7:0] <= hostWdata;
    else if (strobe.ldHi)
      curAddr[15:8] <= hostWdata;
    else if (strobe.dataAcc && autoInc)
      curAddr <= curAddr + 16'd1;
  end

  always_ff @(posedge clk) begin
    if (strobe.dataWr)
      mem[idx] <= hostWdata;
    if (copWrEn && !(strobe.dataWr && copWrAddr == idx))
      mem[copWrAddr] <= copWrData;
  end
endmodule

// File: rtl/cop_ram_port.sv
module cop_ram_port
  import cop_port_pkg::*;
#(
  parameter int RAM_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        hostSel,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  output logic              hostIrq,
  output logic              copRun,
  output logic              copDoorbell,
  input  logic              copEvt0Set,
  input  logic              copEvt1Set,
  input  logic              copWrEn,
  input  logic [RAM_AW-1:0] copWrAddr,
  input  logic [7:0]        copWrData
);
  dpStrobe_t strobe;
  logic [15:0] curAddr;
  logic [7:0] ramData;
  logic autoIncQ;
  logic [NUM_EVT-1:0] evtFlags;

  cop_port_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .hostWdata(hostWdata),
    .evtSet({copEvt1Set, copEvt0Set}), .curAddr(curAddr), .ramData(ramData),
    .strobe(strobe), .hostRdata(hostRdata), .runQ(copRun),
    .autoIncQ(autoIncQ), .bellQ(copDoorbell), .evtFlags(evtFlags)
  );

  cop_port_dp #(.RAM_AW(RAM_AW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .autoInc(autoIncQ),
    .hostWdata(hostWdata), .copWrEn(copWrEn), .copWrAddr(copWrAddr),
    .copWrData(copWrData), .curAddr(curAddr), .ramData(ramData)
  );

  assign hostIrq = |evtFlags;
endmodule

// File: rtl/cop_ram_port_chk.sv
module cop_ram_port_chk (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  hostSel,
  input logic        hostWrEn,
  input logic        hostRdEn,
  input logic [7:0]  hostWdata,
  input logic        hostIrq,
  input logic        copRun,
  input logic        copDoorbell,
  input logic        copEvt0Set,
  input logic        copEvt1Set,
  input logic [15:0] curAddr,
  input logic        autoIncQ,
  input logic [1:0]  evtFlags
);
  logic dataAcc, ctrlWr;
  assign dataAcc = (hostWrEn || hostRdEn) && hostSel == 2'd2;
  assign ctrlWr  = hostWrEn && hostSel == 2'd3;

  // R4
  step_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && autoIncQ) |=> curAddr == $past(curAddr) + 16'd1);

  // R3
  no_step_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && !autoIncQ) |=> $stable(curAddr));

  // R6
  run_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> copRun == $past(hostWdata[0]));

  // R7
  bell_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && hostWdata[2]) |=> copDoorbell);

  // R7
  bell_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    copDoorbell |-> $past(ctrlWr && hostWdata[2]));

  // R8
  irq_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostIrq) |-> $past(copEvt0Set || copEvt1Set));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    copEvt0Set |=> evtFlags[0]);

  // R9
  set_wins1_chk: assert property (@(posedge clk) disable iff (!rstN)
    copEvt1Set |=> evtFlags[1]);
endmodule

bind cop_ram_port cop_ram_port_chk u_chk (.*);

// File: tb/cop_ram_port_bench.sv
module cop_ram_port_bench;
  localparam int RAM_AW = 8;
  localparam int DEPTH  = 1 << RAM_AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] hostSel = '0;
  logic hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic hostIrq, copRun, copDoorbell;
  logic copEvt0Set = 1'b0, copEvt1Set = 1'b0, copWrEn = 1'b0;
  logic [RAM_AW-1:0] copWrAddr = '0;
  logic [7:0] copWrData = '0;

  int total = 0, bad = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  cop_ram_port #(.RAM_AW(RAM_AW)) u_cop_ram_port (.*);

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(logic [1:0] s, logic [7:0] d);
    hostSel = s; hostWdata = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hrd(logic [1:0] s, output logic [7:0] d);
    hostSel = s; hostRdEn = 1'b1;
    #1 d = hostRdata;
    @(negedge clk);
    hostRdEn = 1'b0;
  endtask

  task automatic peek(logic [1:0] s, output logic [7:0] d);
    hostSel = s;
    #1 d = hostRdata;
  endtask

  task automatic ldptr(logic [15:0] a);
    hwr(2'd0, a[7:0]);
    hwr(2'd1, a[15:8]);
  endtask

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] lo, hi;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 run", copRun, 0);
    check("R1 irq", hostIrq, 0);
    peek(2'd3, rv); check("R1 ctrl", rv, 8'h00);
    peek(2'd0, lo); peek(2'd1, hi); check("R1 ptr", {hi, lo}, 16'h0000);

    // R2 split pointer load
    hwr(2'd0, 8'h5A);
    peek(2'd0, lo); peek(2'd1, hi); check("R2 lo", {hi, lo}, 16'h005A);
    hwr(2'd1, 8'hC3);
    peek(2'd0, lo); peek(2'd1, hi); check("R2 hi", {hi, lo}, 16'hC35A);

    // R6 run and stepping bits
    hwr(2'd3, 8'h03);
    check("R6 run", copRun, 1);
    peek(2'd3, rv); check("R6 ctrl", rv, 8'h03);

    // R4 full sweep write with stepping
    ldptr(16'h0000);
    for (int i = 0; i < DEPTH; i++) hwr(2'd2, pat(i));
    peek(2'd0, lo); peek(2'd1, hi); check("R4 ptr after writes", {hi, lo}, 16'(DEPTH));
    ldptr(16'h0000);
    for (int i = 0; i < DEPTH; i++) begin
      hrd(2'd2, rv);
      check("R4 sweep read", rv, pat(i));
    end
    peek(2'd0, lo); peek(2'd1, hi); check("R4 ptr after reads", {hi, lo}, 16'(DEPTH));

    // R10 aliasing above RAM_AW bits
    for (int a = 0; a < 16; a++) begin
      ldptr(16'((a * 16'h1111 + 16'h0700) & 16'hFFFF));
      peek(2'd2, rv);
      check("R10 alias", rv, pat((a * 16'h1111 + 16'h0700) & (DEPTH - 1)));
    end

    // R5 wrap
    ldptr(16'hFFFF);
    hrd(2'd2, rv); check("R5 data at top", rv, pat(DEPTH - 1));
    peek(2'd0, lo); peek(2'd1, hi); check("R5 wrap", {hi, lo}, 16'h0000);

    // R3 no stepping
    hwr(2'd3, 8'h01);
    ldptr(16'h0005);
    hwr(2'd2, 8'hA5);
    hrd(2'd2, rv); check("R3 data", rv, 8'hA5);
    hrd(2'd2, rv); check("R3 data again", rv, 8'hA5);
    peek(2'd0, lo); peek(2'd1, hi); check("R3 ptr held", {hi, lo}, 16'h0005);

    // R7 doorbell
    hostSel = 2'd3; hostWdata = 8'h05; hostWrEn = 1'b1;
    #1 check("R7 bell before", copDoorbell, 0);
    @(negedge clk); hostWrEn = 1'b0;
    check("R7 bell pulse", copDoorbell, 1);
    peek(2'd3, rv); check("R7 bell reads 0", rv, 8'h01);
    @(negedge clk);
    check("R7 bell gone", copDoorbell, 0);

    // R8 event flags and interrupt
    copEvt0Set = 1'b1; @(negedge clk); copEvt0Set = 1'b0;
    check("R8 irq evt0", hostIrq, 1);
    peek(2'd3, rv); check("R8 ctrl evt0", rv, 8'h09);
    copEvt1Set = 1'b1; @(negedge clk); copEvt1Set = 1'b0;
    repeat (3) @(negedge clk);
    peek(2'd3, rv); check("R8 both held", rv, 8'h19);

    // R9 write-1 clear
    hwr(2'd3, 8'h09);
    peek(2'd3, rv); check("R9 clear evt0 only", rv, 8'h11);
    check("R9 irq still", hostIrq, 1);
    hwr(2'd3, 8'h11);
    peek(2'd3, rv); check("R9 clear evt1", rv, 8'h01);
    check("R9 irq low", hostIrq, 0);
    copEvt1Set = 1'b1; hwr(2'd3, 8'h11); copEvt1Set = 1'b0;
    peek(2'd3, rv); check("R9 set wins", rv, 8'h11);
    hwr(2'd3, 8'h11);
    check("R9 cleared", hostIrq, 0);

    // R11 liveness handshake and collision
    copWrEn = 1'b1; copWrAddr = 8'h31; copWrData = 8'hFF;
    @(negedge clk); copWrEn = 1'b0;
    ldptr(16'h0031);
    hrd(2'd2, rv); check("R11 alive read", rv, 8'hFF);
    hwr(2'd2, 8'h00);
    hrd(2'd2, rv); check("R11 alive cleared", rv, 8'h00);
    copWrEn = 1'b1; copWrAddr = 8'h31; copWrData = 8'h77;
    hwr(2'd2, 8'h3C); copWrEn = 1'b0;
    hrd(2'd2, rv); check("R11 host wins", rv, 8'h3C);
    copWrEn = 1'b1; copWrAddr = 8'h32; copWrData = 8'h66;
    hwr(2'd2, 8'h4D); copWrEn = 1'b0;
    ldptr(16'h0032);
    hrd(2'd2, rv); check("R11 cop other byte", rv, 8'h66);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule